// File: doc/BRIEF.md
# USB Endpoint Packet Status Tracker

This block keeps the per-endpoint packet status and byte-count registers of a USB peripheral controller with four endpoints. Each endpoint owns two register sets, A and B, and each set holds a base length, a packet status byte and a transfer count byte. When the serial engine finishes a packet it pulses a one-cycle done strobe. Along with the strobe it gives the endpoint number, the set, the token type, the data toggle, the received byte count, whether a handshake completed and the CRC and PID error flags. The block evaluates that report against the selected set's base length and rewrites the set's status byte in one clock. For OUT packets it also rewrites the transfer count.

The transfer count holds the room left in the buffer, which is the base length minus the bytes received. When an OUT packet carries more bytes than the base length allows, a separate overflow flag is raised and the count stops at zero.

An 8-bit CPU register port reads every register with combinational data and writes the base length and transfer count registers. The done strobe and the CPU port are plain control pins. Neither side has back-pressure, because every report and every write is absorbed in the cycle it is presented.

Top module: `usb_ep_status_tracker`

## Requirements
- R1: Status byte layout: bit 0 ACK, bit 1 Error, bit 2 Time-out, bit 3 Sequence, bit 4 Setup, bit 5 Overflow. Bits 7, 6 and 2 always read 0, because this is a peripheral-only block.
- R2: The token encoding is 00 OUT, 01 IN, 10 SETUP and 11 reserved (handled like IN). On an OUT packet with received bytes not above the base length, the transfer count becomes the base length minus the received bytes. For example, 40h and 16 bytes give 30h.
- R3: On an OUT packet with received bytes above the base length, Overflow is set and the transfer count becomes 00h rather than wrapping.
- R4: IN, SETUP and reserved tokens never set Overflow and leave the transfer count unchanged.
- R5: Setup is 1 after a SETUP-token packet and 0 after any other token.
- R6: Sequence equals the data toggle of the last packet: 0 for DATA0 and 1 for DATA1.
- R7: Error is 1 exactly when the report flags a CRC error or a PID error.
- R8: ACK is 1 exactly when a handshake completed with neither Error nor Overflow.
- R9: The address of a register is endpoint times 10h plus an offset. Set A uses base length at 1, status at 3 and count at 4. Set B uses 9, Bh and Ch. Base length and count are CPU-writable. The status byte ignores CPU writes.
- R10: Reads of unmapped addresses, including endpoint fields 4 and above, return 00h. Writes to unmapped addresses change no register.
- R11: A done strobe updates only the set named by endpoint and set, and the new values are readable in the cycle after the strobe.
- R12: When a CPU count write and an OUT packet hit the same set in one cycle, the packet's count wins. With a non-OUT packet, the CPU value is taken.
- R13: After reset every register reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_done | input | 1 | One-cycle packet-complete strobe |
| pkt_ep | input | 2 | Endpoint number of the report |
| pkt_set | input | 1 | Register set, 0 = A, 1 = B |
| pkt_tok | input | 2 | Token: 00 OUT, 01 IN, 10 SETUP, 11 reserved |
| pkt_toggle | input | 1 | Data PID toggle, 1 = DATA1 |
| pkt_bytes | input | 10 | Bytes received in the packet |
| pkt_hs | input | 1 | Handshake completed |
| pkt_crc_err | input | 1 | CRC5/CRC16 error seen |
| pkt_pid_err | input | 1 | PID error seen |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 8 | CPU register address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, combinational from cpu_addr |

## Verification
On every cycle the assertions check several invariants. The reserved and time-out bits stay clear. ACK never coexists with Error or Overflow. An overflow always leaves a zero count. Status holds between strobes, and count holds when neither a packet nor a write touches it. At most one register is written per cycle, and the packet count wins a same-cycle clash. The bench scenarios are needed for the rest: the arithmetic of base length minus bytes across the boundary values, the toggle, setup and error mapping for each token, and the address map with its unmapped holes. They also confirm that a report leaves every other set untouched.

// File: rtl/usb_eps_pkg.sv
package usb_eps_pkg;
  typedef enum logic [1:0] {
    TOK_OUT   = 2'b00,
    TOK_IN    = 2'b01,
    TOK_SETUP = 2'b10,
    TOK_RSVD  = 2'b11
  } tok_e;

  localparam int ST_ACK   = 0;
  localparam int ST_ERR   = 1;
  localparam int ST_TMO   = 2;
  localparam int ST_SEQ   = 3;
  localparam int ST_SETUP = 4;
  localparam int ST_OVF   = 5;

  localparam int NSETS = 2;

  localparam logic [2:0] SLOT_LEN  = 3'd1;
  localparam logic [2:0] SLOT_STAT = 3'd3;
  localparam logic [2:0] SLOT_CNT  = 3'd4;
endpackage

// File: rtl/eps_eval.sv
module eps_eval
  import usb_eps_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int BYTES_W = 10
) (
  input  logic [1:0]         tok,
  input  logic               toggle,
  input  logic [BYTES_W-1:0] bytes,
  input  logic               hs,
  input  logic               crc_err,
  input  logic               pid_err,
  input  logic [DATA_W-1:0]  base,
  output logic [DATA_W-1:0]  new_stat,
  output logic [DATA_W-1:0]  new_cnt,
  output logic               cnt_upd
);
  logic [BYTES_W-1:0] base_ext;
  logic               is_out;
  logic               ovf;
  logic               err;

  always_comb begin
    base_ext = BYTES_W'(base);
    is_out   = (tok_e'(tok) == TOK_OUT);
    ovf      = is_out && (bytes > base_ext);
    err      = crc_err | pid_err;
    cnt_upd  = is_out;
    new_cnt  = ovf ? '0 : DATA_W'(base_ext - bytes);
    new_stat = '0;
    new_stat[ST_ACK]   = hs && !err && !ovf;
    new_stat[ST_ERR]   = err;
    new_stat[ST_TMO]   = 1'b0;
    new_stat[ST_SEQ]   = toggle;
    new_stat[ST_SETUP] = (tok_e'(tok) == TOK_SETUP);
    new_stat[ST_OVF]   = ovf;
  end
endmodule

// File: rtl/eps_regset.sv
module eps_regset
  import usb_eps_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_upd,
  input  logic [DATA_W-1:0] new_stat,
  input  logic [DATA_W-1:0] new_cnt,
  input  logic              new_cnt_upd,
  input  logic              len_wr,
  input  logic              cnt_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] len_q,
  output logic [DATA_W-1:0] stat_q,
  output logic [DATA_W-1:0] cnt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      stat_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (len_wr) len_q <= wdata;
      if (pkt_upd) stat_q <= new_stat;
      if (pkt_upd && new_cnt_upd) cnt_q <= new_cnt;
      else if (cnt_wr)            cnt_q <= wdata;
    end
  end

  // R1
  rsv_tmo_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[DATA_W-1:6] == '0 && !stat_q[ST_TMO]);

  // R8
  ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[ST_ACK] |-> !stat_q[ST_ERR] && !stat_q[ST_OVF]);

  // R3
  ovf_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_upd && new_stat[ST_OVF] |=> cnt_q == '0 && stat_q[ST_OVF]);

  // R11
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_upd |=> $stable(stat_q));

  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr && !(pkt_upd && new_cnt_upd) |=> $stable(cnt_q));
endmodule

// File: rtl/eps_cpu_port.sv
module eps_cpu_port
  import usb_eps_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cpu_wr,
  input  logic [ADDR_W-1:0]                   cpu_addr,
  input  logic [NUM_EP*NSETS-1:0][DATA_W-1:0] len_q,
  input  logic [NUM_EP*NSETS-1:0][DATA_W-1:0] stat_q,
  input  logic [NUM_EP*NSETS-1:0][DATA_W-1:0] cnt_q,
  output logic [NUM_EP*NSETS-1:0]             len_wr,
  output logic [NUM_EP*NSETS-1:0]             cnt_wr,
  output logic [DATA_W-1:0]                   rdata
);
  localparam int NREG  = NUM_EP * NSETS;
  localparam int EPF_W = ADDR_W - 4;

  logic [EPF_W-1:0] ep_field;
  logic             set_bit;
  logic [2:0]       slot;
  logic             ep_hit;
  int               idx;

  always_comb begin
    ep_field = cpu_addr[ADDR_W-1:4];
    set_bit  = cpu_addr[3];
    slot     = cpu_addr[2:0];
    ep_hit   = (int'(ep_field) < NUM_EP);
    idx      = ep_hit ? (int'(ep_field) * NSETS + int'(set_bit)) : 0;
  end

  always_comb begin
    rdata  = '0;
    len_wr = '0;
    cnt_wr = '0;
    if (ep_hit) begin
      case (slot)
        SLOT_LEN: begin
          rdata       = len_q[idx];
          len_wr[idx] = cpu_wr;
        end
        SLOT_STAT: rdata = stat_q[idx];
        SLOT_CNT: begin
          rdata       = cnt_q[idx];
          cnt_wr[idx] = cpu_wr;
        end
        default: rdata = '0;
      endcase
    end
  end

  // R10
  one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({len_wr, cnt_wr}));

  // R10
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr |-> {len_wr, cnt_wr} == '0);

  logic unused_ok;
  assign unused_ok = (NREG > 0);
endmodule

// File: rtl/usb_ep_status_tracker.sv
module usb_ep_status_tracker
  import usb_eps_pkg::*;
#(
  parameter int NUM_EP  = 4,
  parameter int DATA_W  = 8,
  parameter int BYTES_W = 10,
  parameter int ADDR_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pkt_done,
  input  logic [$clog2(NUM_EP)-1:0] pkt_ep,
  input  logic                      pkt_set,
  input  logic [1:0]                pkt_tok,
  input  logic                      pkt_toggle,
  input  logic [BYTES_W-1:0]        pkt_bytes,
  input  logic                      pkt_hs,
  input  logic                      pkt_crc_err,
  input  logic                      pkt_pid_err,
  input  logic                      cpu_wr,
  input  logic [ADDR_W-1:0]         cpu_addr,
  input  logic [DATA_W-1:0]         cpu_wdata,
  output logic [DATA_W-1:0]         cpu_rdata
);
  localparam int NREG  = NUM_EP * NSETS;
  localparam int IDX_W = $clog2(NREG);

  logic [IDX_W-1:0]             tgt;
  logic [NREG-1:0][DATA_W-1:0]  len_q, stat_q, cnt_q;
  logic [NREG-1:0]              len_wr, cnt_wr;
  logic [DATA_W-1:0]            sel_base;
  logic [DATA_W-1:0]            ev_stat, ev_cnt;
  logic                         ev_cnt_upd;

  assign tgt      = {pkt_ep, pkt_set};
  assign sel_base = len_q[tgt];

  eps_eval #(.DATA_W(DATA_W), .BYTES_W(BYTES_W)) u_eval (
    .tok      (pkt_tok),
    .toggle   (pkt_toggle),
    .bytes    (pkt_bytes),
    .hs       (pkt_hs),
    .crc_err  (pkt_crc_err),
    .pid_err  (pkt_pid_err),
    .base     (sel_base),
    .new_stat (ev_stat),
    .new_cnt  (ev_cnt),
    .cnt_upd  (ev_cnt_upd)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_set
    eps_regset #(.DATA_W(DATA_W)) u_set (
      .clk         (clk),
      .rst_n       (rst_n),
      .pkt_upd     (pkt_done && (tgt == IDX_W'(g))),
      .new_stat    (ev_stat),
      .new_cnt     (ev_cnt),
      .new_cnt_upd (ev_cnt_upd),
      .len_wr      (len_wr[g]),
      .cnt_wr      (cnt_wr[g]),
      .wdata       (cpu_wdata),
      .len_q       (len_q[g]),
      .stat_q      (stat_q[g]),
      .cnt_q       (cnt_q[g])
    );
  end

  eps_cpu_port #(.NUM_EP(NUM_EP), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cpu (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_wr   (cpu_wr),
    .cpu_addr (cpu_addr),
    .len_q    (len_q),
    .stat_q   (stat_q),
    .cnt_q    (cnt_q),
    .len_wr   (len_wr),
    .cnt_wr   (cnt_wr),
    .rdata    (cpu_rdata)
  );

  // R12
  clash_pkt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done && ev_cnt_upd && cnt_wr[tgt] |=> cnt_q[$past(tgt)] == $past(ev_cnt));

  // R9
  len_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done && len_wr[tgt] |=> len_q[$past(tgt)] == $past(cpu_wdata));
endmodule

// File: tb/usb_ep_status_tracker_test.sv
`timescale 1ns/1ps
module usb_ep_status_tracker_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       pkt_done = 0;
  logic [1:0] pkt_ep = 0;
  logic       pkt_set = 0;
  logic [1:0] pkt_tok = 0;
  logic       pkt_toggle = 0;
  logic [9:0] pkt_bytes = 0;
  logic       pkt_hs = 0, pkt_crc_err = 0, pkt_pid_err = 0;
  logic       cpu_wr = 0;
  logic [7:0] cpu_addr = 0, cpu_wdata = 0;
  logic [7:0] cpu_rdata;

  int nchk = 0, nfail = 0;
  int m_len[8], m_stat[8], m_cnt[8];
  bit finished = 0;

  always #2 clk = ~clk;

  usb_ep_status_tracker uut (
    .clk(clk), .rst_n(rst_n), .pkt_done(pkt_done), .pkt_ep(pkt_ep), .pkt_set(pkt_set),
    .pkt_tok(pkt_tok), .pkt_toggle(pkt_toggle), .pkt_bytes(pkt_bytes), .pkt_hs(pkt_hs),
    .pkt_crc_err(pkt_crc_err), .pkt_pid_err(pkt_pid_err), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata));

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input int a, output int v);
    cpu_addr = 8'(a);
    #0.5;
    v = int'(cpu_rdata);
  endtask

  function automatic int ad(input int ep, input int st, input int slot);
    return ep * 16 + st * 8 + slot;
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cpu_addr = 8'(a); cpu_wdata = 8'(d); cpu_wr = 1;
    @(negedge clk);
    cpu_wr = 0;
  endtask

  task automatic check_all(input string tag);
    int v;
    for (int i = 0; i < 8; i++) begin
      rd(ad(i / 2, i % 2, 1), v); chk({tag, " len"}, v, m_len[i]);
      rd(ad(i / 2, i % 2, 3), v); chk({tag, " stat"}, v, m_stat[i]);
      rd(ad(i / 2, i % 2, 4), v); chk({tag, " cnt"}, v, m_cnt[i]);
    end
  endtask

  task automatic model_pkt(input int i, input int tok, input int tg, input int by,
                           input int hs, input int ce, input int pe);
    int ovf, err;
    ovf = (tok == 0 && by > m_len[i]) ? 1 : 0;
    err = ce | pe;
    m_stat[i] = ((hs && !err && !ovf) ? 1 : 0) | (err << 1) | (tg << 3) |
                ((tok == 2 ? 1 : 0) << 4) | (ovf << 5);
    if (tok == 0) m_cnt[i] = ovf ? 0 : m_len[i] - by;
  endtask

  task automatic drive_pkt(input int ep, input int st, input int tok, input int tg,
                           input int by, input int hs, input int ce, input int pe);
    @(negedge clk);
    pkt_ep = 2'(ep); pkt_set = st[0]; pkt_tok = 2'(tok); pkt_toggle = tg[0];
    pkt_bytes = 10'(by); pkt_hs = hs[0]; pkt_crc_err = ce[0]; pkt_pid_err = pe[0];
    pkt_done = 1;
    @(negedge clk);
    pkt_done = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int v, i, ep, st;
    int bases[5] = '{0, 1, 16, 64, 255};
    int blist[6];
    for (int k = 0; k < 8; k++) begin m_len[k] = 0; m_stat[k] = 0; m_cnt[k] = 0; end
    repeat (3) @(negedge clk);
    check_all("R13 reset");
    rst_n = 1;
    @(negedge clk);
    check_all("R13 after release");

    // R9: base length and count writable, status ignores writes
    for (int k = 0; k < 8; k++) begin
      wr(ad(k / 2, k % 2, 1), 8'h10 + k); m_len[k] = 8'h10 + k;
      wr(ad(k / 2, k % 2, 4), 8'hA0 + k); m_cnt[k] = 8'hA0 + k;
      wr(ad(k / 2, k % 2, 3), 8'hFF);
    end
    check_all("R9 map");

    // R10: unmapped reads zero, writes ignored
    foreach (blist[k]) blist[k] = 0;
    for (int a = 0; a < 256; a += 7) begin
      if ((a >> 4) < 4 && ((a & 7) == 1 || (a & 7) == 3 || (a & 7) == 4)) continue;
      rd(a, v); chk("R10 unmapped read", v, 0);
      wr(a, 8'h5A);
    end
    check_all("R10 unmapped write");

    // Sweep: every set, base values, byte counts around the boundary, tokens, flags
    for (int k = 0; k < 8; k++) begin
      ep = k / 2; st = k % 2;
      for (int bi = 0; bi < 5; bi++) begin
        wr(ad(ep, st, 1), bases[bi]); m_len[k] = bases[bi];
        blist = '{0, 1, (bases[bi] > 0 ? bases[bi] - 1 : 2), bases[bi], bases[bi] + 1, 300};
        for (int bx = 0; bx < 6; bx++) begin
          for (int tok = 0; tok < 4; tok++) begin
            for (int f = 0; f < 8; f++) begin
              int tg, hs, ce, pe, ovf_e, prev_cnt;
              tg = (bx + f + tok) & 1; hs = f & 1; ce = (f >> 1) & 1; pe = (f >> 2) & 1;
              prev_cnt = m_cnt[k];
              drive_pkt(ep, st, tok, tg, blist[bx], hs, ce, pe);
              model_pkt(k, tok, tg, blist[bx], hs, ce, pe);
              ovf_e = (tok == 0 && blist[bx] > bases[bi]) ? 1 : 0;
              rd(ad(ep, st, 3), v);
              chk("R8 ack", v & 1, m_stat[k] & 1);
              chk("R7 error", (v >> 1) & 1, ce | pe);
              chk("R6 sequence", (v >> 3) & 1, tg);
              chk("R5 setup", (v >> 4) & 1, tok == 2 ? 1 : 0);
              chk("R3 overflow flag", (v >> 5) & 1, ovf_e);
              chk("R1 reserved/timeout", v & 8'hC4, 0);
              chk("R4 no overflow off OUT", (tok != 0) ? ((v >> 5) & 1) : 0, 0);
              rd(ad(ep, st, 4), v);
              if (tok != 0) chk("R4 count held", v, prev_cnt);
              else if (ovf_e) chk("R3 count saturates", v, 0);
              else chk("R2 remaining count", v, bases[bi] - blist[bx]);
              if (f == 0 && tok == 0) check_all("R11 other sets");
            end
          end
        end
      end
    end

    // R2 worked example
    wr(ad(2, 0, 1), 8'h40); m_len[4] = 8'h40;
    drive_pkt(2, 0, 0, 1, 16, 1, 0, 0); model_pkt(4, 0, 1, 16, 1, 0, 0);
    rd(ad(2, 0, 4), v); chk("R2 40h-16", v, 8'h30);
    rd(ad(2, 0, 3), v); chk("R8 ack example", v, 8'h09);

    // R12: same-cycle clash
    i = 3;
    wr(ad(1, 1, 1), 8'h20); m_len[i] = 8'h20;
    @(negedge clk);
    pkt_ep = 2'd1; pkt_set = 1; pkt_tok = 2'd0; pkt_toggle = 0; pkt_bytes = 10'd5;
    pkt_hs = 1; pkt_crc_err = 0; pkt_pid_err = 0; pkt_done = 1;
    cpu_addr = 8'(ad(1, 1, 4)); cpu_wdata = 8'hAA; cpu_wr = 1;
    @(negedge clk);
    pkt_done = 0; cpu_wr = 0;
    model_pkt(i, 0, 0, 5, 1, 0, 0);
    rd(ad(1, 1, 4), v); chk("R12 OUT wins", v, 8'h1B);
    @(negedge clk);
    pkt_tok = 2'd1; pkt_done = 1;
    cpu_addr = 8'(ad(1, 1, 4)); cpu_wdata = 8'h77; cpu_wr = 1;
    @(negedge clk);
    pkt_done = 0; cpu_wr = 0;
    model_pkt(i, 1, 0, 5, 1, 0, 0); m_cnt[i] = 8'h77;
    rd(ad(1, 1, 4), v); chk("R12 IN lets CPU write", v, 8'h77);
    check_all("R11 final");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule